// File: doc/BRIEF.md
# Command Slot Dispatcher with Queued-Tag Tracking

This per-port block chooses which issued command slot goes to the execution engine next. It also tracks the tags of queued commands from the moment they start until they complete. Software sets bits in a 32-entry issue vector. When the port is enabled and the device is neither busy nor requesting data, the dispatcher picks the lowest pending slot and offers it to the engine through a valid/ready handshake. The engine then reports one of three results.

- **Immediate completion:** the slot's issue bit is retired at once.
- **Device left busy:** the slot is remembered as the busy slot. Its issue bit stays set until both device busy and data-request drop.
- **Queued command:** the tag is taken from the frame's tag byte and marked active, and the issue bit is retired.

Queued commands complete out of order through a separate completion input. Each completion does the following:

- clears the tag's active bit;
- sets its finished bit;
- on failure, also sets its error bit;
- loads a completion status byte;
- pulses a set-device-bits event.

A read strobe on the active register returns the active vector with the finished tags removed, and then empties the finished vector.

The controller is a four-state machine:

- **IDLE:** waits for a dispatch condition.
- **ISSUE:** offers the chosen slot.
- **WAIT:** waits for the engine's result.
- **HOLD:** holds a non-queued slot while the device is busy.

Its transitions are:

- dispatch: IDLE to ISSUE;
- accept: ISSUE to WAIT;
- retire: WAIT to IDLE;
- park: WAIT to HOLD;
- release: HOLD to IDLE.

A port reset returns it to IDLE from any state.

Top module: `slot_dispatch_top`

## Requirements
- R1: A slot is offered (`start_valid` high) only after the port enable is set and the issue vector is nonzero; the slot offered is the lowest-numbered set issue bit, and its issue bit stays set while it is offered.
- R2: While `dev_bsy` or `dev_drq` is high in IDLE, no slot is offered and the pending issue bits are unchanged.
- R3: A result code 2'b01 (device busy) stores the slot in `busy_slot` and keeps its issue bit. Once both `dev_bsy` and `dev_drq` are low, the controller clears that issue bit and sets `busy_slot` back to 6'h3F (none).
- R4: A result code 2'b00 (immediate) clears the offered slot's issue bit at the edge that takes the result.
- R5: A result code 2'b10 (queued) takes the tag from bits [7:3] of `done_tag_field`, sets that bit of `act_vec`, and clears the slot's issue bit.
- R6: A queued result whose tag is already active leaves `act_vec` unchanged and produces a one-cycle `tag_err_evt` pulse in the next cycle.
- R7: A queued completion clears the tag's active bit, sets its finished bit, and produces a one-cycle `sdb_evt` pulse in the next cycle.
- R8: A failed completion also sets the tag's bit in `err_vec`, and `cpl_status` becomes 8'h41. A successful completion sets `cpl_status` to 8'h50.
- R9: `act_rdata` equals the active vector with the finished bits removed. When `act_rd` is high, the active vector takes that value and `fin_vec` becomes zero.
- R10: Reset and `port_rst` clear the issue, active, finished and error vectors, set `busy_slot` to 6'h3F, and return the controller to IDLE.
- R11: An issue write ORs `issue_wdata` into the issue vector. `err_clr` clears the error bits it selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_rst | input | 1 | Synchronous port reset |
| start_en | input | 1 | Port command-processing enable |
| dev_bsy | input | 1 | Device busy flag |
| dev_drq | input | 1 | Device data-request flag |
| issue_wr | input | 1 | Issue vector write strobe |
| issue_wdata | input | 32 | Slots to mark issued |
| issue_vec | output | 32 | Pending issue vector |
| start_valid | output | 1 | Slot offered to the engine |
| start_slot | output | 5 | Offered slot number |
| start_ready | input | 1 | Engine accepts the offered slot |
| done_valid | input | 1 | Engine result valid |
| done_code | input | 2 | 00 immediate, 01 busy, 10 queued |
| done_tag_field | input | 8 | Tag byte of the command frame |
| q_done_valid | input | 1 | Queued completion strobe |
| q_done_tag | input | 5 | Completed tag |
| q_done_fail | input | 1 | Completion failed |
| act_rd | input | 1 | Active register read strobe |
| err_clr | input | 32 | Error bits to clear |
| act_vec | output | 32 | Active tag vector |
| fin_vec | output | 32 | Finished tag vector |
| err_vec | output | 32 | Failed tag vector |
| act_rdata | output | 32 | Active register read value |
| busy_slot | output | 6 | Held busy slot, 6'h3F when none |
| sdb_evt | output | 1 | Queued-completion event pulse |
| tag_err_evt | output | 1 | Tag-in-use event pulse |
| cpl_status | output | 8 | Status byte of last completion |

## Verification
The hardest case to reach is the HOLD state with the busy flag already low and data-request still high. Release must wait for both flags, so the slot's issue bit must survive this partial release. The stimulus returns a busy result while raising `dev_bsy`, then swaps busy for data-request for several cycles before dropping it. A second hard case is a duplicate tag. To reach it, the bench issues a new queued command that carries an already active tag while that tag's completion is still outstanding. A behavioural model follows every cycle and compares all outputs continuously.

// File: rtl/slot_disp_pkg.sv
package slot_disp_pkg;
    typedef enum logic [1:0] {
        D_IDLE  = 2'd0,
        D_ISSUE = 2'd1,
        D_WAIT  = 2'd2,
        D_HOLD  = 2'd3
    } disp_state_e;

    typedef enum logic [1:0] {
        RES_DONE   = 2'b00,
        RES_BUSY   = 2'b01,
        RES_QUEUED = 2'b10,
        RES_RSVD   = 2'b11
    } result_e;

    localparam logic [7:0] ST_ERR   = 8'h01;
    localparam logic [7:0] ST_SEEK  = 8'h10;
    localparam logic [7:0] ST_READY = 8'h40;
    localparam int         TAG_LSB  = 3;
endpackage

// File: rtl/slot_pick.sv
module slot_pick #(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic [NSLOT-1:0] req,
    output logic             any,
    output logic [SW-1:0]    idx
);
    logic [NSLOT-1:0] below;
    logic [NSLOT-1:0] first;

    assign below[0] = 1'b0;
    genvar g;
    generate
        for (g = 1; g < NSLOT; g++) begin : g_below
            assign below[g] = below[g-1] | req[g-1];
        end
        for (g = 0; g < NSLOT; g++) begin : g_first
            assign first[g] = req[g] & ~below[g];
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < NSLOT; i++) begin
            if (first[i]) idx = idx | SW'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/slot_dispatch_fsm.sv
module slot_dispatch_fsm
    import slot_disp_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_rst,
    input  logic             start_en,
    input  logic             dev_bsy,
    input  logic             dev_drq,
    input  logic             issue_wr,
    input  logic [NSLOT-1:0] issue_wdata,
    input  logic             start_ready,
    input  logic             done_valid,
    input  logic [1:0]       done_code,
    input  logic [7:0]       done_tag_field,
    output logic [NSLOT-1:0] issue_vec,
    output logic             start_valid,
    output logic [SW-1:0]    start_slot,
    output logic [SW:0]      busy_slot,
    output logic             q_start_valid,
    output logic [SW-1:0]    q_start_tag
);
    localparam int            BW      = SW + 1;
    localparam logic [BW-1:0] NO_SLOT = '1;

    disp_state_e      state, nxt;
    logic [SW-1:0]    cur_slot;
    logic [BW-1:0]    busy_r;
    logic [NSLOT-1:0] issue_r;
    logic [NSLOT-1:0] clr_mask;
    logic             pick_any;
    logic [SW-1:0]    pick_idx;
    logic             dev_idle;
    logic             do_dispatch;
    logic             do_park;
    logic             do_release;
    logic             do_retire;
    result_e          res;

    assign res      = result_e'(done_code);
    assign dev_idle = !dev_bsy && !dev_drq;

    slot_pick #(.NSLOT(NSLOT), .SW(SW)) u_pick (
        .req (issue_r),
        .any (pick_any),
        .idx (pick_idx)
    );

    assign do_dispatch = (state == D_IDLE) && start_en && pick_any && dev_idle;
    assign do_park     = (state == D_WAIT) && done_valid && (res == RES_BUSY);
    assign do_retire   = (state == D_WAIT) && done_valid && (res != RES_BUSY);
    assign do_release  = (state == D_HOLD) && dev_idle;

    // next-state
    always_comb begin
        nxt = state;
        unique case (state)
            D_IDLE:  if (do_dispatch) nxt = D_ISSUE;
            D_ISSUE: if (start_ready) nxt = D_WAIT;
            D_WAIT:  begin
                if (do_park)        nxt = D_HOLD;
                else if (do_retire) nxt = D_IDLE;
            end
            D_HOLD:  if (do_release) nxt = D_IDLE;
            default: nxt = D_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        state <= D_IDLE;
        else if (port_rst) state <= D_IDLE;
        else               state <= nxt;
    end

    // outputs
    always_comb begin
        clr_mask      = '0;
        q_start_valid = 1'b0;
        q_start_tag   = done_tag_field[TAG_LSB +: SW];
        start_valid   = 1'b0;
        unique case (state)
            D_IDLE:  ;
            D_ISSUE: start_valid = 1'b1;
            D_WAIT:  begin
                if (do_retire) clr_mask = NSLOT'(1) << cur_slot;
                if (do_retire && res == RES_QUEUED) q_start_valid = 1'b1;
            end
            D_HOLD:  if (do_release) clr_mask = NSLOT'(1) << busy_r[SW-1:0];
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            issue_r  <= '0;
            busy_r   <= NO_SLOT;
            cur_slot <= '0;
        end else if (port_rst) begin
            issue_r  <= '0;
            busy_r   <= NO_SLOT;
            cur_slot <= '0;
        end else begin
            issue_r <= (issue_r & ~clr_mask) | (issue_wr ? issue_wdata : '0);
            if (do_dispatch) cur_slot <= pick_idx;
            if (do_park)          busy_r <= {1'b0, cur_slot};
            else if (do_release)  busy_r <= NO_SLOT;
        end
    end

    assign issue_vec  = issue_r;
    assign start_slot = cur_slot;
    assign busy_slot  = busy_r;

    // R2: no offer follows an IDLE cycle with the device busy
    p_no_dispatch_busy_r2: assert property (@(posedge clk) disable iff (!rst_n || port_rst)
        (state == D_IDLE && !dev_idle) |=> (state != D_ISSUE));
    // R1: an offered slot is still pending
    p_offer_pending_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_valid |-> issue_r[cur_slot]);
    // R3: the held slot keeps its issue bit
    p_hold_pending_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == D_HOLD) |-> (busy_r != NO_SLOT && issue_r[busy_r[SW-1:0]]));
    // R3: release frees the busy slot
    p_release_r3: assert property (@(posedge clk) disable iff (!rst_n || port_rst)
        (state == D_HOLD && dev_idle) |=> (busy_r == NO_SLOT && state == D_IDLE));
endmodule

// File: rtl/tag_tracker.sv
module tag_tracker
    import slot_disp_pkg::*;
#(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_rst,
    input  logic             q_start_valid,
    input  logic [SW-1:0]    q_start_tag,
    input  logic             q_done_valid,
    input  logic [SW-1:0]    q_done_tag,
    input  logic             q_done_fail,
    input  logic             act_rd,
    input  logic [NSLOT-1:0] err_clr,
    output logic [NSLOT-1:0] act_vec,
    output logic [NSLOT-1:0] fin_vec,
    output logic [NSLOT-1:0] err_vec,
    output logic [NSLOT-1:0] act_rdata,
    output logic             sdb_evt,
    output logic             tag_err_evt,
    output logic [7:0]       cpl_status
);
    logic [NSLOT-1:0] act_r, fin_r, err_r;
    logic [NSLOT-1:0] set_m, done_m, act_nxt, fin_nxt, err_nxt, act_after_rd;
    logic             conflict;

    always_comb begin
        conflict     = q_start_valid && act_r[q_start_tag];
        set_m        = (q_start_valid && !conflict) ? (NSLOT'(1) << q_start_tag) : '0;
        done_m       = q_done_valid ? (NSLOT'(1) << q_done_tag) : '0;
        act_after_rd = act_rd ? (act_r & ~fin_r) : act_r;
        act_nxt      = (act_after_rd & ~done_m) | set_m;
        fin_nxt      = (act_rd ? '0 : fin_r) | done_m;
        err_nxt      = (err_r & ~err_clr) | (q_done_fail ? done_m : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act_r <= '0; fin_r <= '0; err_r <= '0;
            sdb_evt <= 1'b0; tag_err_evt <= 1'b0; cpl_status <= '0;
        end else if (port_rst) begin
            act_r <= '0; fin_r <= '0; err_r <= '0;
            sdb_evt <= 1'b0; tag_err_evt <= 1'b0; cpl_status <= '0;
        end else begin
            act_r       <= act_nxt;
            fin_r       <= fin_nxt;
            err_r       <= err_nxt;
            sdb_evt     <= q_done_valid;
            tag_err_evt <= conflict;
            if (q_done_valid)
                cpl_status <= q_done_fail ? (ST_READY | ST_ERR) : (ST_READY | ST_SEEK);
        end
    end

    assign act_vec   = act_r;
    assign fin_vec   = fin_r;
    assign err_vec   = err_r;
    assign act_rdata = act_r & ~fin_r;

    // R7: every completion yields an event and a finished bit
    p_sdb_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n || port_rst)
        q_done_valid |=> (sdb_evt && fin_r[$past(q_done_tag)]));
    // R9: an active read empties the finished vector
    p_rd_clears_r9: assert property (@(posedge clk) disable iff (!rst_n || port_rst)
        (act_rd && !q_done_valid) |=> (fin_r == '0));
    // R6: a duplicate tag leaves the active set unchanged
    p_dup_tag_r6: assert property (@(posedge clk) disable iff (!rst_n || port_rst)
        (conflict && !q_done_valid && !act_rd) |=> (act_r == $past(act_r)));
endmodule

// File: rtl/slot_dispatch_top.sv
module slot_dispatch_top #(
    parameter int NSLOT = 32,
    parameter int SW    = $clog2(NSLOT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_rst,
    input  logic             start_en,
    input  logic             dev_bsy,
    input  logic             dev_drq,
    input  logic             issue_wr,
    input  logic [NSLOT-1:0] issue_wdata,
    output logic [NSLOT-1:0] issue_vec,
    output logic             start_valid,
    output logic [SW-1:0]    start_slot,
    input  logic             start_ready,
    input  logic             done_valid,
    input  logic [1:0]       done_code,
    input  logic [7:0]       done_tag_field,
    input  logic             q_done_valid,
    input  logic [SW-1:0]    q_done_tag,
    input  logic             q_done_fail,
    input  logic             act_rd,
    input  logic [NSLOT-1:0] err_clr,
    output logic [NSLOT-1:0] act_vec,
    output logic [NSLOT-1:0] fin_vec,
    output logic [NSLOT-1:0] err_vec,
    output logic [NSLOT-1:0] act_rdata,
    output logic [SW:0]      busy_slot,
    output logic             sdb_evt,
    output logic             tag_err_evt,
    output logic [7:0]       cpl_status
);
    logic          q_start_valid;
    logic [SW-1:0] q_start_tag;

    slot_dispatch_fsm #(.NSLOT(NSLOT), .SW(SW)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .port_rst       (port_rst),
        .start_en       (start_en),
        .dev_bsy        (dev_bsy),
        .dev_drq        (dev_drq),
        .issue_wr       (issue_wr),
        .issue_wdata    (issue_wdata),
        .start_ready    (start_ready),
        .done_valid     (done_valid),
        .done_code      (done_code),
        .done_tag_field (done_tag_field),
        .issue_vec      (issue_vec),
        .start_valid    (start_valid),
        .start_slot     (start_slot),
        .busy_slot      (busy_slot),
        .q_start_valid  (q_start_valid),
        .q_start_tag    (q_start_tag)
    );

    tag_tracker #(.NSLOT(NSLOT), .SW(SW)) u_tags (
        .clk           (clk),
        .rst_n         (rst_n),
        .port_rst      (port_rst),
        .q_start_valid (q_start_valid),
        .q_start_tag   (q_start_tag),
        .q_done_valid  (q_done_valid),
        .q_done_tag    (q_done_tag),
        .q_done_fail   (q_done_fail),
        .act_rd        (act_rd),
        .err_clr       (err_clr),
        .act_vec       (act_vec),
        .fin_vec       (fin_vec),
        .err_vec       (err_vec),
        .act_rdata     (act_rdata),
        .sdb_evt       (sdb_evt),
        .tag_err_evt   (tag_err_evt),
        .cpl_status    (cpl_status)
    );

    // R10: port reset empties all tracking state
    p_port_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
        port_rst |=> (issue_vec == '0 && act_vec == '0 && fin_vec == '0 && busy_slot == '1));
endmodule

// File: tb/slot_dispatch_top_tb.sv
module slot_dispatch_top_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        port_rst = 0, start_en = 0, dev_bsy = 0, dev_drq = 0;
    logic        issue_wr = 0;
    logic [31:0] issue_wdata = 0;
    logic [31:0] issue_vec;
    logic        start_valid;
    logic [4:0]  start_slot;
    logic        start_ready = 1;
    logic        done_valid = 0;
    logic [1:0]  done_code = 0;
    logic [7:0]  done_tag_field = 0;
    logic        q_done_valid = 0;
    logic [4:0]  q_done_tag = 0;
    logic        q_done_fail = 0;
    logic        act_rd = 0;
    logic [31:0] err_clr = 0;
    logic [31:0] act_vec, fin_vec, err_vec, act_rdata;
    logic [5:0]  busy_slot;
    logic        sdb_evt, tag_err_evt;
    logic [7:0]  cpl_status;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2 clk = ~clk;   // 250 MHz

    slot_dispatch_top u_dut (
        .clk(clk), .rst_n(rst_n), .port_rst(port_rst), .start_en(start_en),
        .dev_bsy(dev_bsy), .dev_drq(dev_drq), .issue_wr(issue_wr),
        .issue_wdata(issue_wdata), .issue_vec(issue_vec), .start_valid(start_valid),
        .start_slot(start_slot), .start_ready(start_ready), .done_valid(done_valid),
        .done_code(done_code), .done_tag_field(done_tag_field),
        .q_done_valid(q_done_valid), .q_done_tag(q_done_tag), .q_done_fail(q_done_fail),
        .act_rd(act_rd), .err_clr(err_clr), .act_vec(act_vec), .fin_vec(fin_vec),
        .err_vec(err_vec), .act_rdata(act_rdata), .busy_slot(busy_slot),
        .sdb_evt(sdb_evt), .tag_err_evt(tag_err_evt), .cpl_status(cpl_status)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int          m_state;      // 0 idle, 1 offering, 2 awaiting result, 3 holding
    int          m_cur;
    int          m_busy;
    logic [31:0] m_issue, m_act, m_fin, m_err;
    logic        m_sdb, m_terr;
    logic [7:0]  m_status;

    initial begin
        m_state = 0; m_cur = 0; m_busy = 63; m_issue = 0; m_act = 0; m_fin = 0;
        m_err = 0; m_sdb = 0; m_terr = 0; m_status = 0;
    end

    always @(posedge clk) begin
        if (!rst_n || port_rst) begin
            m_state = 0; m_cur = 0; m_busy = 63; m_issue = 0; m_act = 0;
            m_fin = 0; m_err = 0; m_sdb = 0; m_terr = 0; m_status = 0;
        end else begin
            logic [31:0] clr, newact, newfin;
            int tag;
            clr = 0;
            newact = m_act;
            m_terr = 0;
            if (act_rd) newact = newact & ~m_fin;
            newfin = act_rd ? 32'h0 : m_fin;
            if (q_done_valid) begin
                newact[q_done_tag] = 1'b0;
                newfin[q_done_tag] = 1'b1;
                if (q_done_fail) m_err[q_done_tag] = 1'b1;
                m_status = q_done_fail ? 8'h41 : 8'h50;
            end
            m_err = m_err & ~err_clr;
            if (q_done_valid && q_done_fail) m_err[q_done_tag] = 1'b1;
            case (m_state)
                0: if (start_en && m_issue != 0 && !dev_bsy && !dev_drq) begin
                    for (int i = 31; i >= 0; i--) if (m_issue[i]) m_cur = i;
                    m_state = 1;
                end
                1: if (start_ready) m_state = 2;
                2: if (done_valid) begin
                    if (done_code == 2'b01) begin
                        m_busy = m_cur; m_state = 3;
                    end else begin
                        clr[m_cur] = 1'b1; m_state = 0;
                        if (done_code == 2'b10) begin
                            tag = int'(done_tag_field >> 3);
                            if (m_act[tag]) m_terr = 1;
                            else newact[tag] = 1'b1;
                        end
                    end
                end
                default: if (!dev_bsy && !dev_drq) begin
                    clr[m_busy] = 1'b1; m_busy = 63; m_state = 0;
                end
            endcase
            m_issue = (m_issue & ~clr) | (issue_wr ? issue_wdata : 32'h0);
            m_act = newact;
            m_fin = newfin;
            m_sdb = q_done_valid;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R11 issue_vec model", issue_vec, m_issue);
            chk("R1 start_valid model", 32'(start_valid), 32'(m_state == 1));
            if (m_state == 1) chk("R1 start_slot model", 32'(start_slot), 32'(m_cur));
            chk("R3 busy_slot model", 32'(busy_slot), 32'(m_busy));
            chk("R5 act_vec model", act_vec, m_act);
            chk("R7 fin_vec model", fin_vec, m_fin);
            chk("R8 err_vec model", err_vec, m_err);
            chk("R7 sdb_evt model", 32'(sdb_evt), 32'(m_sdb));
            chk("R6 tag_err_evt model", 32'(tag_err_evt), 32'(m_terr));
            chk("R8 cpl_status model", 32'(cpl_status), 32'(m_status));
            chk("R9 act_rdata model", act_rdata, m_act & ~m_fin);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic wr_issue(input logic [31:0] v);
        issue_wr = 1; issue_wdata = v; tick(); issue_wr = 0; issue_wdata = 0;
    endtask

    task automatic serve(input logic [1:0] code, input logic [7:0] field,
                         input bit raise_bsy, output int slot);
        while (!start_valid) tick();
        slot = int'(start_slot);
        tick();
        done_valid = 1; done_code = code; done_tag_field = field;
        if (raise_bsy) dev_bsy = 1;
        tick();
        done_valid = 0; done_code = 0; done_tag_field = 0;
    endtask

    task automatic q_complete(input logic [4:0] tag, input bit fail);
        q_done_valid = 1; q_done_tag = tag; q_done_fail = fail;
        tick();
        q_done_valid = 0; q_done_fail = 0;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin : main
        int s;
        tick(); tick();
        rst_n = 1;
        tick();
        chk("R10 reset issue", issue_vec, 0);
        chk("R10 reset busy_slot", 32'(busy_slot), 63);
        chk("R10 reset act", act_vec, 0);

        // R1: no offer while disabled; R11 OR-write
        wr_issue(32'h10);
        wr_issue(32'h04);
        repeat (3) tick();
        chk("R1 no offer while disabled", 32'(start_valid), 0);
        chk("R11 issue OR", issue_vec, 32'h14);

        // R1/R4 lowest slot first, immediate retire
        start_en = 1;
        serve(2'b00, 8'h00, 0, s);
        chk("R1 lowest slot", s, 2);
        chk("R4 immediate clear", issue_vec, 32'h10);
        serve(2'b00, 8'h00, 0, s);
        chk("R1 next slot", s, 4);
        chk("R4 immediate clear 2", issue_vec, 32'h0);

        // R2 device busy blocks dispatch
        dev_bsy = 1;
        wr_issue(32'h1);
        repeat (3) tick();
        chk("R2 no offer when busy", 32'(start_valid), 0);
        chk("R2 pending kept", issue_vec, 32'h1);
        dev_bsy = 0;

        // R3 busy result, partial release
        serve(2'b01, 8'h00, 1, s);
        chk("R3 busy slot recorded", 32'(busy_slot), 0);
        chk("R3 issue kept", issue_vec, 32'h1);
        dev_bsy = 0; dev_drq = 1;
        repeat (3) tick();
        chk("R3 held on drq", issue_vec, 32'h1);
        chk("R3 busy slot held", 32'(busy_slot), 0);
        dev_drq = 0;
        tick();
        chk("R3 released issue", issue_vec, 32'h0);
        chk("R3 released busy slot", 32'(busy_slot), 63);

        // R5 queued start, tag 5 from 8'h2B
        wr_issue(32'h100);
        serve(2'b10, 8'h2B, 0, s);
        chk("R5 active tag", act_vec, 32'h20);
        chk("R5 issue cleared", issue_vec, 32'h0);

        // R6 duplicate tag
        wr_issue(32'h200);
        serve(2'b10, 8'h2F, 0, s);
        chk("R6 tag error event", 32'(tag_err_evt), 1);
        chk("R6 active unchanged", act_vec, 32'h20);
        tick();
        chk("R6 event one cycle", 32'(tag_err_evt), 0);

        // R7/R8 successful completion
        q_complete(5'd5, 0);
        chk("R7 sdb event", 32'(sdb_evt), 1);
        chk("R7 active cleared", act_vec, 32'h0);
        chk("R7 finished set", fin_vec, 32'h20);
        chk("R8 ok status", 32'(cpl_status), 32'h50);
        tick();
        chk("R7 event one cycle", 32'(sdb_evt), 0);

        // R8 failed completion, tag 9 from 8'h48
        wr_issue(32'h1);
        serve(2'b10, 8'h48, 0, s);
        q_complete(5'd9, 1);
        chk("R8 error bit", err_vec, 32'h200);
        chk("R8 fail status", 32'(cpl_status), 32'h41);
        chk("R7 finished accumulate", fin_vec, 32'h220);

        // R9 active read, tag 3 from 8'h18 left active
        wr_issue(32'h2);
        serve(2'b10, 8'h18, 0, s);
        chk("R9 read value", act_rdata, 32'h8);
        act_rd = 1; tick(); act_rd = 0;
        chk("R9 finished emptied", fin_vec, 32'h0);
        chk("R9 active kept", act_vec, 32'h8);

        // R11 error clear
        err_clr = 32'h200; tick(); err_clr = 0;
        chk("R11 error cleared", err_vec, 32'h0);

        // R10 port reset
        start_en = 0;
        wr_issue(32'hF0);
        port_rst = 1; tick(); port_rst = 0;
        chk("R10 port reset issue", issue_vec, 32'h0);
        chk("R10 port reset act", act_vec, 32'h0);
        chk("R10 port reset busy", 32'(busy_slot), 63);
        tick();
        summary();
    end
endmodule